// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Register with Output Hold Stage

This block gathers a serial bit stream into a chain of shift stages and, on command, copies the chain into a separate hold register that drives the parallel outputs. It is organised as a number of 8-stage devices joined end to end, so a chain of `DEV_COUNT` devices holds `8*DEV_COUNT` bits. The last stage of each device feeds the first stage of the next one, and the last stage of the whole chain is brought out as a serial cascade output for further chaining.

The shift side and the hold side each have their own rising-edge clock and their own asynchronous, active-low clear, so each side can be loaded or zeroed without disturbing the other. The parallel outputs always show the hold register and never the shift stages directly. The data interface is a bare serial bit qualified by the shift clock edge: there is no valid/ready handshake and no back-pressure, so every rising shift edge consumes one bit, and the host alone paces the stream.

Top module: `sr_cascade_store`

## Requirements
- R1: While `shift_clr_n` is low, every shift stage is zero and `ser_out` reads 0, regardless of `shift_clk` edges; the clear acts without a clock edge.
- R2: While `store_clr_n` is low, `par_q` is all zeros, regardless of `store_clk` edges; the clear acts without a clock edge.
- R3: On each rising edge of `shift_clk` (with `shift_clr_n` high), stage 0 takes `ser_in` and stage k takes the previous value of stage k-1. Stage k of device d is chain stage 8*d+k.
- R4: On each rising edge of `store_clk` (with `store_clr_n` high), `par_q[k]` takes the value of chain stage k, without inversion, for all stages at once.
- R5: `par_q` changes only on a `store_clk` rising edge or through `store_clr_n`; shift edges alone never change it.
- R6: `ser_out` equals the last chain stage (stage 8*DEV_COUNT-1), and stage 7 of device d feeds stage 0 of device d+1.
- R7: Asserting `shift_clr_n` low leaves `par_q` unchanged, and asserting `store_clr_n` low leaves the shift stages unchanged.
- R8: When `shift_clk` and `store_clk` rise at the same instant, the hold register captures the shift stages as they stood before that edge, so `par_q` lags the shift chain by one edge.
- R9: Repeated `store_clk` edges without any shift edge leave `par_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Rising-edge clock of the shift chain |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| store_clk | input | 1 | Rising-edge clock of the hold register |
| store_clr_n | input | 1 | Asynchronous active-low clear of the hold register |
| ser_in | input | 1 | Serial data into chain stage 0 |
| par_q | output | 8*DEV_COUNT | Hold register contents; bit k mirrors chain stage k at the last store edge |
| ser_out | output | 1 | Last chain stage, for cascading into another chain |

## Verification
On every shift edge the assertions check that stage 0 took the serial bit and that each stage took its neighbour's old value, and on every store edge that the hold register took the chain as sampled at that edge; they also check that each side reads zero whenever its clear is low. Those edge-local checks cannot show that one side's clear leaves the other side untouched, that shift edges never disturb the parallel outputs, or that data really travels across a device boundary into the cascade output over many edges. Those behaviours, and the one-edge lag when both clocks rise together, are shown only by the bench's sequences, which compare the outputs against a shadow model of the chain.

// File: rtl/sr_cascade_pkg.sv
package sr_cascade_pkg;
  // Number of stages in one device of the chain.
  localparam int unsigned DEV_STAGES = 8;
endpackage

// File: rtl/sr_dev_shift.sv
module sr_dev_shift #(
  parameter int unsigned WIDTH = sr_cascade_pkg::DEV_STAGES
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stage_q,
  output logic             cascade_o
);
  logic [WIDTH-1:0] stage_r;
  logic             armed_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stage_r <= '0;
    else        stage_r <= {stage_r[WIDTH-2:0], ser_in};
  end

  assign stage_q   = stage_r;
  assign cascade_o = stage_r[WIDTH-1];

  // Marks that at least one edge has passed since the last clear.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_shift_clear_R1: assert property (@(posedge clk)
    !clr_n |-> stage_r == '0);

  assert_stage0_loads_R3: assert property (@(posedge clk) disable iff (!clr_n)
    armed_q |-> stage_r[0] == $past(ser_in));

  assert_stages_advance_R3: assert property (@(posedge clk) disable iff (!clr_n)
    armed_q |-> stage_r[WIDTH-1:1] == $past(stage_r[WIDTH-2:0]));
endmodule

// File: rtl/sr_hold_reg.sv
module sr_hold_reg #(
  parameter int unsigned WIDTH = sr_cascade_pkg::DEV_STAGES
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] hold_r;
  logic             armed_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) hold_r <= '0;
    else        hold_r <= d;
  end

  assign q = hold_r;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_store_clear_R2: assert property (@(posedge clk)
    !clr_n |-> hold_r == '0);

  // The captured value is the chain as sampled before the edge (R8 too).
  assert_store_capture_R4: assert property (@(posedge clk) disable iff (!clr_n)
    armed_q |-> hold_r == $past(d));
endmodule

// File: rtl/sr_cascade_store.sv
module sr_cascade_store #(
  parameter int unsigned DEV_COUNT = 2
) (
  input  logic                                            shift_clk,
  input  logic                                            shift_clr_n,
  input  logic                                            store_clk,
  input  logic                                            store_clr_n,
  input  logic                                            ser_in,
  output logic [DEV_COUNT*sr_cascade_pkg::DEV_STAGES-1:0] par_q,
  output logic                                            ser_out
);
  localparam int unsigned DW    = sr_cascade_pkg::DEV_STAGES;
  localparam int unsigned TOTAL = DEV_COUNT * DW;

  logic [DEV_COUNT:0] link_w;
  logic [TOTAL-1:0]   chain_w;

  assign link_w[0] = ser_in;

  for (genvar d = 0; d < DEV_COUNT; d++) begin : g_dev
    sr_dev_shift #(.WIDTH(DW)) u_shift (
      .clk       (shift_clk),
      .clr_n     (shift_clr_n),
      .ser_in    (link_w[d]),
      .stage_q   (chain_w[d*DW +: DW]),
      .cascade_o (link_w[d+1])
    );

    sr_hold_reg #(.WIDTH(DW)) u_hold (
      .clk   (store_clk),
      .clr_n (store_clr_n),
      .d     (chain_w[d*DW +: DW]),
      .q     (par_q[d*DW +: DW])
    );
  end

  assign ser_out = link_w[DEV_COUNT];

  assert_serout_zero_in_clear_R1: assert property (@(posedge shift_clk)
    !shift_clr_n |-> !ser_out);

  assert_parq_zero_in_clear_R2: assert property (@(posedge store_clk)
    !store_clr_n |-> par_q == '0);
endmodule

// File: tb/sr_cascade_store_tb_top.sv
module sr_cascade_store_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 2;
  localparam int TOT  = NDEV * 8;

  typedef struct packed {
    logic [15:0] data;
    logic [15:0] exp_par;
    logic        exp_ser;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'hA5C3, 16'hA5C3, 1'b1},
    '{16'h0001, 16'h0001, 1'b0},
    '{16'h8000, 16'h8000, 1'b1},
    '{16'hFFFF, 16'hFFFF, 1'b1},
    '{16'h3C96, 16'h3C96, 1'b0}
  };

  logic           shift_clk = 0, store_clk = 0;
  logic           shift_clr_n = 0, store_clr_n = 0;
  logic           ser_in = 0;
  logic [TOT-1:0] par_q;
  logic           ser_out;
  logic [TOT-1:0] exp_sh = '0;
  logic [TOT-1:0] saved;
  int checks = 0, errors = 0;

  sr_cascade_store #(.DEV_COUNT(NDEV)) dut_i (
    .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
    .store_clk(store_clk), .store_clr_n(store_clr_n),
    .ser_in(ser_in), .par_q(par_q), .ser_out(ser_out)
  );

  task automatic chk(input string req, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    #(CLK_PERIOD/2) shift_clk = 1;
    #(CLK_PERIOD/2) shift_clk = 0;
    if (shift_clr_n) exp_sh = {exp_sh[TOT-2:0], b};
  endtask

  task automatic store_pulse();
    #(CLK_PERIOD/2) store_clk = 1;
    #(CLK_PERIOD/2) store_clk = 0;
  endtask

  task automatic both_pulse(input logic b);
    ser_in = b;
    #(CLK_PERIOD/2);
    shift_clk = 1;
    store_clk = 1;
    #(CLK_PERIOD/2);
    shift_clk = 0;
    store_clk = 0;
    exp_sh = {exp_sh[TOT-2:0], b};
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    // Reset state with both clears low; edges during clear are ignored (R1, R2).
    #(CLK_PERIOD);
    shift_bit(1);
    store_pulse();
    chk("R1 ser_out in clear", {{(TOT-1){1'b0}}, ser_out}, '0);
    chk("R2 par_q in clear", par_q, '0);
    #(CLK_PERIOD/2);
    shift_clr_n = 1;
    store_clr_n = 1;
    exp_sh = '0;
    #(CLK_PERIOD/2);

    // Vector table: shift a word MSB first, then store (R3, R4, R6).
    for (int i = 0; i < 5; i++) begin
      for (int b = 15; b >= 0; b--) shift_bit(VECS[i].data[b]);
      chk("R6 ser_out after word", {{(TOT-1){1'b0}}, ser_out}, {{(TOT-1){1'b0}}, VECS[i].exp_ser});
      store_pulse();
      chk("R4 par_q after store", par_q, VECS[i].exp_par);
    end

    // R5: shift edges alone leave par_q alone.
    saved = par_q;
    shift_bit(1); shift_bit(0); shift_bit(1);
    chk("R5 par_q after shifts", par_q, saved);
    store_pulse();
    chk("R3 par_q shows shifted chain", par_q, exp_sh);

    // R8: both clocks together capture the pre-edge chain.
    saved = exp_sh;
    both_pulse(0);
    chk("R8 par_q lags by one edge", par_q, saved);
    store_pulse();
    chk("R8 next store shows new chain", par_q, exp_sh);

    // R9: repeated stores without shifts.
    store_pulse(); store_pulse();
    chk("R9 par_q steady over stores", par_q, exp_sh);

    // R2 / R7: store clear zeroes par_q, leaves chain.
    #(CLK_PERIOD/2) store_clr_n = 0;
    #(CLK_PERIOD/2);
    chk("R2 par_q zero without clock", par_q, '0);
    store_pulse();
    chk("R2 par_q zero despite store edge", par_q, '0);
    #(CLK_PERIOD/2) store_clr_n = 1;
    #(CLK_PERIOD/2);
    store_pulse();
    chk("R7 chain kept through store clear", par_q, exp_sh);

    // R1 / R7: shift clear zeroes chain, leaves par_q.
    saved = par_q;
    #(CLK_PERIOD/2) shift_clr_n = 0;
    #(CLK_PERIOD/2);
    exp_sh = '0;
    shift_bit(1);
    chk("R1 ser_out zero in shift clear", {{(TOT-1){1'b0}}, ser_out}, '0);
    chk("R7 par_q kept through shift clear", par_q, saved);
    #(CLK_PERIOD/2) shift_clr_n = 1;
    #(CLK_PERIOD/2);
    store_pulse();
    chk("R1 chain zero after clear", par_q, '0);

    // R6: ones cross the device boundary and reach ser_out.
    for (int k = 0; k < 9; k++) shift_bit(1);
    store_pulse();
    chk("R6 device boundary crossing", par_q, 16'h01FF);
    chk("R6 ser_out still zero", {{(TOT-1){1'b0}}, ser_out}, '0);
    for (int k = 0; k < 7; k++) shift_bit(1);
    chk("R6 ser_out reaches last stage", {{(TOT-1){1'b0}}, ser_out}, {{(TOT-1){1'b0}}, 1'b1});
    store_pulse();
    chk("R4 full chain", par_q, 16'hFFFF);

    finish_run();
  end
endmodule